// File: doc/BRIEF.md
# Unaligned Byte-to-Word Merge Packer

This block turns a byte stream bound for an arbitrary byte address into a run of whole, aligned word writes for a word-wide flash programmer. A transfer starts with a byte address and a byte count. For each destination word the block first fetches the word already in memory through a read port. It then builds the new word lane by lane. A lane that the transfer covers takes the next byte from the stream. A lane outside the transfer, whether before the start or after the last byte, keeps the byte already stored there. Every write therefore carries a full word, and no byte enables are used.

Lane 0 is the lowest byte address of a word, and it lands in the most significant byte of the write data. Each write waits for a response code. A non-zero code ends the transfer at once and is reported as the result. When the last byte has been written with code zero, a one-cycle done pulse reports result zero. A byte count of zero finishes on the next cycle without touching memory.

Top module: `byte_word_packer`

## Requirements
- R1: Every read and write address is word aligned: the start address with its low log2(WORD_BYTES) bits cleared for the first word, then one word further for each following word.
- R2: Byte lane i of a word (address base+i) is carried in write and read data bits [8*(WORD_BYTES-1-i)+7 : 8*(WORD_BYTES-1-i)]. Lane 0 is the most significant byte.
- R3: A lane below the start offset, or at or beyond offset plus remaining count, is written back with the byte read from memory for that word.
- R4: The covered lanes take consecutive stream bytes in address order. in_ready is high only while a covered lane is being filled, so exactly byte_count bytes are consumed by a successful transfer.
- R5: Each word is read exactly once, and the read completes before its write is requested. A transfer writes ceil((offset+count)/WORD_BYTES) words.
- R6: A non-zero write response ends the transfer. The result equals that code, and no further read or write is requested.
- R7: done is a single-cycle pulse. result is 0 after the last word is written with response 0, and busy is low afterwards. After reset, busy, done, rd_req, wr_req and in_ready are all low.
- R8: A start with byte_count 0 gives done with result 0 on the next cycle and makes no read or write.
- R9: While wr_req is high and no response has arrived, wr_addr and wr_data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer. Taken only while busy is low |
| start_addr | input | ADDR_W | Byte address of the first stream byte |
| byte_count | input | CNT_W | Number of stream bytes |
| busy | output | 1 | A transfer is in progress |
| in_valid | input | 1 | Stream byte is valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte is accepted on this edge when in_valid is also high |
| rd_req | output | 1 | Request to read the existing word at rd_addr |
| rd_addr | output | ADDR_W | Aligned read address |
| rd_valid | input | 1 | Read data is present. Completes the read |
| rd_data | input | 8*WORD_BYTES | Existing word, lane 0 in the most significant byte |
| wr_req | output | 1 | Word write request |
| wr_addr | output | ADDR_W | Aligned write address |
| wr_data | output | 8*WORD_BYTES | Merged word, lane 0 in the most significant byte |
| wr_resp_valid | input | 1 | Write response is present. Completes the write |
| wr_resp | input | RESP_W | Write response code, 0 meaning success |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | RESP_W | Final code, valid with done |

## Verification
Directed transfers cover each shape of word coverage: a fully aligned word, a run inside one word, a single byte at the first lane and at the last lane, a head-and-tail run, an aligned multi-word run, and a zero count. These separate a wrong offset mask, an off-by-one coverage bound and a reversed lane order. Random transfers with random start addresses and lengths, stalls on the stream, and slow read and write responses then compare the whole memory image against a byte-wise model. Any lane taken from the wrong source shows up as a changed neighbouring byte. Injected failure codes on the first word and on a later word check that the run stops there, with exactly the expected bytes written.

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int RESP_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic [CNT_W-1:0]        byte_count,
  output logic                    busy,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  output logic                    rd_req,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic                    rd_valid,
  input  logic [8*WORD_BYTES-1:0] rd_data,
  output logic                    wr_req,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [8*WORD_BYTES-1:0] wr_data,
  input  logic                    wr_resp_valid,
  input  logic [RESP_W-1:0]       wr_resp,
  output logic                    done,
  output logic [RESP_W-1:0]       result
);
  // WORD_BYTES is meant to be 2 or 4.
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam logic [OFF_W-1:0]  LANE_LAST = OFF_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(WORD_BYTES - 1);
  localparam logic [CNT_W-1:0]  WB_CNT    = CNT_W'(WORD_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE, S_WRITE} state_t;

  state_t              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [OFF_W-1:0]    off_q;
  logic [OFF_W-1:0]    lane_q;
  logic [CNT_W-1:0]    rem_q;
  logic [WORD_W-1:0]   old_q;
  logic [WORD_W-1:0]   word_q;
  logic                done_q;
  logic [RESP_W-1:0]   result_q;

  logic                covered;
  logic                take;
  logic [WORD_W-1:0]   old_sh;
  logic [7:0]          lane_byte;
  logic [CNT_W-1:0]    head_room;

  assign covered   = (lane_q >= off_q) && (CNT_W'(lane_q - off_q) < rem_q);
  assign take      = (state_q == S_MERGE) && (!covered || in_valid);
  assign old_sh    = old_q << {lane_q, 3'b000};
  assign lane_byte = covered ? in_data : old_sh[WORD_W-1 -: 8];
  assign head_room = WB_CNT - CNT_W'(off_q);

  assign busy     = (state_q != S_IDLE);
  assign in_ready = (state_q == S_MERGE) && covered;
  assign rd_req   = (state_q == S_READ);
  assign rd_addr  = addr_q;
  assign wr_req   = (state_q == S_WRITE);
  assign wr_addr  = addr_q;
  assign wr_data  = word_q;
  assign done     = done_q;
  assign result   = result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      off_q    <= '0;
      lane_q   <= '0;
      rem_q    <= '0;
      old_q    <= '0;
      word_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          if (byte_count == '0) begin
            done_q   <= 1'b1;
            result_q <= '0;
          end else begin
            addr_q  <= start_addr & ~OFF_MASK;
            off_q   <= start_addr[OFF_W-1:0];
            rem_q   <= byte_count;
            state_q <= S_READ;
          end
        end
        S_READ: if (rd_valid) begin
          old_q   <= rd_data;
          lane_q  <= '0;
          state_q <= S_MERGE;
        end
        S_MERGE: if (take) begin
          word_q <= {word_q[WORD_W-9:0], lane_byte};
          lane_q <= lane_q + 1'b1;
          if (lane_q == LANE_LAST) state_q <= S_WRITE;
        end
        S_WRITE: if (wr_resp_valid) begin
          if (wr_resp != '0) begin
            done_q   <= 1'b1;
            result_q <= wr_resp;
            state_q  <= S_IDLE;
          end else if (rem_q <= head_room) begin
            done_q   <= 1'b1;
            result_q <= '0;
            state_q  <= S_IDLE;
          end else begin
            rem_q   <= rem_q - head_room;
            addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
            off_q   <= '0;
            state_q <= S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> ((wr_addr & OFF_MASK) == '0));

  a_r4_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!rd_req && !wr_req));

  a_r6_error_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_resp_valid && wr_resp != '0) |=> (done && !busy && result == $past(wr_resp)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> (done && result == '0 && !busy));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_resp_valid) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: tb/test_byte_word_packer.sv
module test_byte_word_packer;
  localparam int WB = 4;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic busy;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [8*WB-1:0] rd_data = '0;
  logic wr_req;
  logic [AW-1:0] wr_addr;
  logic [8*WB-1:0] wr_data;
  logic wr_resp_valid = 1'b0;
  logic [RW-1:0] wr_resp = '0;
  logic done;
  logic [RW-1:0] result;

  always #2 clk = ~clk;

  byte_word_packer #(.WORD_BYTES(WB), .ADDR_W(AW), .CNT_W(CW), .RESP_W(RW)) i_byte_word_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .byte_count(byte_count),
    .busy(busy), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_resp_valid(wr_resp_valid), .wr_resp(wr_resp), .done(done), .result(result));

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] src [64];
  int n_tests = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [8*WB-1:0] read_word(input int a);
    logic [8*WB-1:0] w = '0;
    for (int i = 0; i < WB; i++) w = {w[8*WB-9:0], mem[(a + i) & 255]};
    return w;
  endfunction

  function automatic int n_words(input int a, input int cnt);
    return ((a % WB) + cnt + WB - 1) / WB;
  endfunction

  function automatic int min2(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  task automatic run(input int a, input int cnt, input int err_word, input int code, input int gap);
    int ptr = 0, reads = 0, writes = 0, cycles = 0, nw, base, applied, exp_bytes, bad;
    bit got_done = 0;
    logic [RW-1:0] res = '0;
    nw = n_words(a, cnt);
    base = a - (a % WB);
    for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    applied = (err_word < 0) ? cnt : min2(cnt, err_word * WB - (a % WB));
    if (applied < 0) applied = 0;
    for (int i = 0; i < applied; i++) exp_mem[(a + i) & 255] = src[i];
    exp_bytes = (err_word < 0) ? cnt : min2(cnt, (err_word + 1) * WB - (a % WB));

    @(negedge clk);
    start = 1'b1; start_addr = AW'(a); byte_count = CW'(cnt);
    while (!got_done && cycles < 3000) begin
      @(negedge clk);
      start = 1'b0;
      cycles++;
      if (done) begin
        got_done = 1; res = result;
      end else begin
        in_valid = (ptr < cnt) && (($urandom % 100) >= gap);
        in_data = (ptr < 64) ? src[ptr] : 8'h00;
        if (in_valid && in_ready) ptr++;
        rd_valid = rd_req && (($urandom % 3) != 0);
        rd_data = read_word(int'(rd_addr));
        if (rd_valid) begin
          check(rd_addr == AW'(base + reads * WB), "R1", "read address", int'(rd_addr), base + reads * WB);
          check(reads == writes, "R5", "read before write", reads, writes);
          reads++;
        end
        wr_resp_valid = wr_req && (($urandom % 3) != 0);
        wr_resp = (writes == err_word) ? RW'(code) : '0;
        if (wr_resp_valid) begin
          check(wr_addr == AW'(base + writes * WB), "R1", "write address", int'(wr_addr), base + writes * WB);
          if (wr_resp == '0)
            for (int i = 0; i < WB; i++) mem[(int'(wr_addr) + i) & 255] = wr_data[8*(WB-1-i) +: 8];
          writes++;
        end
      end
    end
    in_valid = 1'b0; rd_valid = 1'b0; wr_resp_valid = 1'b0; wr_resp = '0;
    check(got_done, "R7", "watchdog, done seen", int'(got_done), 1);
    if (cnt == 0) begin
      check(cycles == 1, "R8", "zero count done latency", cycles, 1);
      check(reads == 0 && writes == 0, "R8", "zero count accesses", reads + writes, 0);
    end
    if (err_word < 0) begin
      check(res == '0, "R7", "result", int'(res), 0);
      check(writes == (cnt == 0 ? 0 : nw), "R5", "word writes", writes, (cnt == 0 ? 0 : nw));
      check(reads == writes, "R5", "word reads", reads, writes);
    end else begin
      check(res == RW'(code), "R6", "error result", int'(res), code);
      check(writes == err_word + 1, "R6", "writes until error", writes, err_word + 1);
    end
    check(ptr == exp_bytes, "R4", "bytes consumed", ptr, exp_bytes);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, "R2 R3", "memory bytes differing", bad, 0);
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || rd_req || wr_req || busy) bad++;
    end
    check(bad == 0, "R6 R7", "activity after done", bad, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req && !wr_req && !in_ready, "R7", "reset outputs",
          int'({busy, done, rd_req, wr_req, in_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(40, 0, -1, 0, 0);     // R8 zero count
    run(8, 4, -1, 0, 0);      // aligned full word
    run(5, 2, -1, 0, 30);     // inside one word, R3 head and tail
    run(12, 1, -1, 0, 0);     // single byte, lane 0 (R2)
    run(19, 1, -1, 0, 0);     // single byte, last lane
    run(1, 9, -1, 0, 50);     // head and tail partial
    run(32, 12, -1, 0, 20);   // aligned multi-word
    run(66, 30, -1, 0, 40);
    run(10, 20, 1, 2, 10);    // R6 error on second word
    run(100, 8, 0, 3, 0);     // R6 error on first word
    for (int t = 0; t < 40; t++) begin
      int a = int'($urandom % 180);
      int c = int'($urandom % 61);
      int nw = n_words(a, c);
      int ew = (c != 0 && ($urandom % 5) == 0) ? int'($urandom % nw) : -1;
      run(a, c, ew, 1 + int'($urandom % 3), int'($urandom % 60));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule